// File: doc/BRIEF.md
# Impulse Radio Packet Receive Sequencer

This block is the control core of an impulse-radio packet receiver. It stays quiet until the host says the upper layer can take a packet. It then watches a squared-energy value for activity and hands off to an external acquisition engine. It confirms the acquired timing with one correlation sample and waits while the demodulation template is built. Next it searches the demodulated bit stream for the start-of-frame byte, reads the one-byte payload length and captures that many payload bytes. At the end it raises a packet-ready pulse to the host and goes back to idle.

During the start-of-frame search, a weak correlation sample means the packet has ended without a start-of-frame byte, for example because the receiver joined a transmission part way through. The sequencer then gives up and goes back to energy detection, so it does not wait forever for a byte that will never arrive. The energy and correlation thresholds are inputs, so the host can set them.

Top module: `ir_rx_sequencer`

## Requirements
- R1: After reset, rxState is 0 (idle), and byteValid, pktReady, pktLen, byteData and byteIdx are all zero.
- R2: In idle, every input except hostReady is ignored. A one-cycle hostReady moves rxState to 1 (energy detection) at the next clock edge.
- R3: In energy detection, energySq strictly greater than energyThresh moves rxState to 2 (acquisition). A value equal to or below the threshold keeps rxState at 1.
- R4: In acquisition, acqFail returns to state 1 and wins over acqDone in the same cycle. acqDone alone moves to state 3 (verify). In verify, the first corrValid cycle goes to state 4 (template) if corrMag is strictly greater than corrThresh, and to state 1 otherwise.
- R5: In state 4, tmplDone moves to state 5 (start-of-frame search). The bit history is cleared on entry.
- R6: In state 5, each bitValid shifts bitIn into an 8-bit window at the LSB end, so the earliest bit lands in the MSB. The window is matched against 0x55 on every bit, but a match counts only once at least 8 bits have arrived since entering state 5. A match moves to state 6 (length read).
- R7: In state 5, a cycle with corrValid high and corrMag strictly below corrThresh returns to state 1. This wins over a start-of-frame match in the same cycle.
- R8: In state 6, the next 8 bits, MSB first, are latched onto pktLen. A length of zero raises pktReady one clock after the eighth bit and returns to state 0. Otherwise the block enters state 7 (payload).
- R9: In state 7, every 8 bits, MSB first, form one payload byte. The byte appears on byteData with its 0-based position on byteIdx, and byteValid is high for exactly one cycle, one clock after the byte's last bit.
- R10: The cycle that presents byte number pktLen-1 also carries a one-cycle pktReady pulse, and rxState returns to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReady | input | 1 | Strobe from the host: the upper layer can take a packet |
| energyThresh | input | EN_W | Energy detection threshold |
| energySq | input | EN_W | Squared received-signal value |
| corrThresh | input | CORR_W | Correlation magnitude threshold |
| corrMag | input | CORR_W | Absolute correlation value |
| corrValid | input | 1 | corrMag is valid in this cycle |
| acqDone | input | 1 | Acquisition engine finished |
| acqFail | input | 1 | Acquisition engine failed |
| tmplDone | input | 1 | Demodulation template built |
| bitValid | input | 1 | bitIn carries a demodulated bit |
| bitIn | input | 1 | Demodulated bit |
| rxState | output | 3 | Current state code, 0 to 7 |
| pktLen | output | 8 | Latched payload length |
| byteData | output | 8 | Captured payload byte |
| byteIdx | output | 8 | Position of byteData in the payload |
| byteValid | output | 1 | One-cycle strobe for byteData |
| pktReady | output | 1 | One-cycle packet-ready interrupt |

## Verification
The assertions assume that the acquisition, template and bit inputs come as single-cycle strobes. They also assume that pktReady is only ever observed as the result of a completed length or payload byte. The stimulus therefore drives each control flag for exactly one cycle and only in the state that consumes it. Demodulated bits are sent with random idle gaps of zero to two cycles. Correlation samples appear during the search only when a test means them to end it, since a weak sample there is meant to abandon the packet.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ENERGY   = 3'd1,
    ST_ACQUIRE  = 3'd2,
    ST_VERIFY   = 3'd3,
    ST_TEMPLATE = 3'd4,
    ST_SFD      = 3'd5,
    ST_LENGTH   = 3'd6,
    ST_PAYLOAD  = 3'd7
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearBits;
    logic shiftEn;
    logic latchLen;
    logic emitByte;
    logic notify;
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic energyHit;
    logic corrPass;
    logic corrLow;
    logic sfdHit;
    logic byteDone;
    logic lenZero;
    logic lastByte;
  } dpStatus_t;

endpackage

// File: rtl/irrx_ctrl.sv
module irrx_ctrl
  import irrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReady,
  input  logic        corrValid,
  input  logic        acqDone,
  input  logic        acqFail,
  input  logic        tmplDone,
  input  logic        bitValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output rxState_e    state
);

  rxState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (hostReady) nextState = ST_ENERGY;
      ST_ENERGY: if (status.energyHit) nextState = ST_ACQUIRE;
      ST_ACQUIRE: begin
        if (acqFail)      nextState = ST_ENERGY;
        else if (acqDone) nextState = ST_VERIFY;
      end
      ST_VERIFY: begin
        if (corrValid) nextState = status.corrPass ? ST_TEMPLATE : ST_ENERGY;
      end
      ST_TEMPLATE: begin
        if (tmplDone) begin
          nextState        = ST_SFD;
          strobe.clearBits = 1'b1;
        end
      end
      ST_SFD: begin
        if (status.corrLow) begin
          nextState = ST_ENERGY;
        end else begin
          strobe.shiftEn = bitValid;
          if (status.sfdHit) begin
            nextState        = ST_LENGTH;
            strobe.clearBits = 1'b1;
          end
        end
      end
      ST_LENGTH: begin
        strobe.shiftEn = bitValid;
        if (status.byteDone) begin
          strobe.latchLen = 1'b1;
          if (status.lenZero) begin
            strobe.notify = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            nextState = ST_PAYLOAD;
          end
        end
      end
      ST_PAYLOAD: begin
        strobe.shiftEn = bitValid;
        if (status.byteDone) begin
          strobe.emitByte = 1'b1;
          if (status.lastByte) begin
            strobe.notify = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/irrx_dpath.sv
module irrx_dpath
  import irrx_pkg::*;
#(
  parameter int EN_W     = 16,
  parameter int CORR_W   = 16,
  parameter int BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SFD_CODE = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EN_W-1:0]   energyThresh,
  input  logic [EN_W-1:0]   energySq,
  input  logic [CORR_W-1:0] corrThresh,
  input  logic [CORR_W-1:0] corrMag,
  input  logic              corrValid,
  input  logic              bitValid,
  input  logic              bitIn,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [BYTE_W-1:0] pktLen,
  output logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] byteIdx,
  output logic              byteValid,
  output logic              pktReady
);

  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int FILL_W = CNT_W + 1;
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [FILL_W-1:0] FILL_MIN = FILL_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] window;
  logic [CNT_W-1:0]  bitCnt;
  logic [FILL_W-1:0] fillCnt;
  logic [BYTE_W-1:0] byteCnt;

  assign window = {shiftReg[BYTE_W-2:0], bitIn};

  always_comb begin
    status.energyHit = energySq > energyThresh;
    status.corrPass  = corrMag > corrThresh;
    status.corrLow   = corrValid && (corrMag < corrThresh);
    status.sfdHit    = bitValid && (window == SFD_CODE) && (fillCnt >= FILL_MIN);
    status.byteDone  = bitValid && (bitCnt == LAST_BIT);
    status.lenZero   = window == '0;
    status.lastByte  = ({1'b0, byteCnt} + (BYTE_W+1)'(1)) == {1'b0, pktLen};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      fillCnt  <= '0;
    end else if (strobe.clearBits) begin
      shiftReg <= strobe.shiftEn ? window : '0;
      bitCnt   <= '0;
      fillCnt  <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= window;
      bitCnt   <= bitCnt + CNT_W'(1);
      if (fillCnt < FILL_MIN) fillCnt <= fillCnt + FILL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktLen    <= '0;
      byteCnt   <= '0;
      byteData  <= '0;
      byteIdx   <= '0;
      byteValid <= 1'b0;
      pktReady  <= 1'b0;
    end else begin
      byteValid <= strobe.emitByte;
      pktReady  <= strobe.notify;
      if (strobe.latchLen) begin
        pktLen  <= window;
        byteCnt <= '0;
      end
      if (strobe.emitByte) begin
        byteData <= window;
        byteIdx  <= byteCnt;
        byteCnt  <= byteCnt + BYTE_W'(1);
      end
    end
  end

endmodule

// File: rtl/ir_rx_sequencer.sv
module ir_rx_sequencer
  import irrx_pkg::*;
#(
  parameter int EN_W   = 16,
  parameter int CORR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReady,
  input  logic [EN_W-1:0]   energyThresh,
  input  logic [EN_W-1:0]   energySq,
  input  logic [CORR_W-1:0] corrThresh,
  input  logic [CORR_W-1:0] corrMag,
  input  logic              corrValid,
  input  logic              acqDone,
  input  logic              acqFail,
  input  logic              tmplDone,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic [2:0]        rxState,
  output logic [7:0]        pktLen,
  output logic [7:0]        byteData,
  output logic [7:0]        byteIdx,
  output logic              byteValid,
  output logic              pktReady
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  rxState_e    state;

  irrx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostReady(hostReady), .corrValid(corrValid),
    .acqDone(acqDone), .acqFail(acqFail), .tmplDone(tmplDone),
    .bitValid(bitValid), .status(status), .strobe(strobe), .state(state)
  );

  irrx_dpath #(.EN_W(EN_W), .CORR_W(CORR_W), .BYTE_W(8)) u_dpath (
    .clk(clk), .rstN(rstN), .energyThresh(energyThresh), .energySq(energySq),
    .corrThresh(corrThresh), .corrMag(corrMag), .corrValid(corrValid),
    .bitValid(bitValid), .bitIn(bitIn), .strobe(strobe), .status(status),
    .pktLen(pktLen), .byteData(byteData), .byteIdx(byteIdx),
    .byteValid(byteValid), .pktReady(pktReady)
  );

  assign rxState = state;

endmodule

// File: rtl/irrx_checker.sv
module irrx_checker #(
  parameter int EN_W   = 16,
  parameter int CORR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic [EN_W-1:0]   energyThresh,
  input logic [EN_W-1:0]   energySq,
  input logic [CORR_W-1:0] corrThresh,
  input logic [CORR_W-1:0] corrMag,
  input logic              corrValid,
  input logic              acqFail,
  input logic [2:0]        rxState,
  input logic              byteValid,
  input logic              pktReady
);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == 3'd0 && !hostReady) |=> rxState == 3'd0);

  p_energy_go_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == 3'd1 && energySq > energyThresh) |=> rxState == 3'd2);

  p_acq_fail_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == 3'd2 && acqFail) |=> rxState == 3'd1);

  p_abandon_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == 3'd5 && corrValid && corrMag < corrThresh) |=> rxState == 3'd1);

  p_byte_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |=> !pktReady);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> rxState == 3'd0);

endmodule

bind ir_rx_sequencer irrx_checker #(.EN_W(EN_W), .CORR_W(CORR_W)) u_checker (
  .clk(clk), .rstN(rstN), .hostReady(hostReady), .energyThresh(energyThresh),
  .energySq(energySq), .corrThresh(corrThresh), .corrMag(corrMag),
  .corrValid(corrValid), .acqFail(acqFail), .rxState(rxState),
  .byteValid(byteValid), .pktReady(pktReady)
);

// File: tb/sim_ir_rx_sequencer.sv
module sim_ir_rx_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReady = 1'b0;
  logic [15:0] energyThresh = 16'd100;
  logic [15:0] energySq = 16'd0;
  logic [15:0] corrThresh = 16'd500;
  logic [15:0] corrMag = 16'd0;
  logic        corrValid = 1'b0;
  logic        acqDone = 1'b0;
  logic        acqFail = 1'b0;
  logic        tmplDone = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [2:0]  rxState;
  logic [7:0]  pktLen, byteData, byteIdx;
  logic        byteValid, pktReady;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ir_rx_sequencer u0 (
    .clk(clk), .rstN(rstN), .hostReady(hostReady), .energyThresh(energyThresh),
    .energySq(energySq), .corrThresh(corrThresh), .corrMag(corrMag),
    .corrValid(corrValid), .acqDone(acqDone), .acqFail(acqFail),
    .tmplDone(tmplDone), .bitValid(bitValid), .bitIn(bitIn), .rxState(rxState),
    .pktLen(pktLen), .byteData(byteData), .byteIdx(byteIdx),
    .byteValid(byteValid), .pktReady(pktReady)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stateAfterLen(input int len);
    return (len == 0) ? 0 : 7;
  endfunction

  function automatic logic [7:0] pickByte();
    return 8'($urandom_range(0, 255));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    bitValid = 1'b1;
    bitIn    = b;
    tick();
    bitValid = 1'b0;
  endtask

  task automatic gap();
    repeat ($urandom_range(0, 2)) tick();
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sendBit(v[i]);
      if (i != 0) gap();
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick();
    sig = 1'b0;
  endtask

  task automatic goToSearch();
    pulse(hostReady);
    chk("R2 host ready", rxState, 1);
    energySq = 16'd101;
    tick();
    energySq = 16'd0;
    chk("R3 energy cross", rxState, 2);
    pulse(acqDone);
    chk("R4 acq done", rxState, 3);
    corrMag = 16'd800;
    pulse(corrValid);
    corrMag = 16'd0;
    chk("R4 verify pass", rxState, 4);
    pulse(tmplDone);
    chk("R5 template done", rxState, 5);
  endtask

  task automatic runPacket(input int pre, input int len);
    logic [7:0] data [0:15];
    goToSearch();
    for (int i = 0; i < pre; i++) begin
      sendBit(1'b1);
      gap();
    end
    chk("R6 preamble no match", rxState, 5);
    sendByte(8'h55);
    chk("R6 sfd found", rxState, 6);
    gap();
    sendByte(8'(len));
    chk("R8 length latched", pktLen, len);
    chk("R8 state after length", rxState, stateAfterLen(len));
    if (len == 0) chk("R8 zero length ready", pktReady, 1);
    for (int k = 0; k < len; k++) begin
      data[k] = pickByte();
      gap();
      sendByte(data[k]);
      chk("R9 byte valid", byteValid, 1);
      chk("R9 byte data", byteData, data[k]);
      chk("R9 byte index", byteIdx, k);
      chk("R10 ready on last", pktReady, (k == len - 1) ? 1 : 0);
      chk("R10 state", rxState, (k == len - 1) ? 0 : 7);
    end
    tick();
    chk("R10 ready one cycle", pktReady, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R1 reset state", rxState, 0);
    chk("R1 reset valid", byteValid, 0);
    chk("R1 reset ready", pktReady, 0);
    chk("R1 reset len", pktLen, 0);
    chk("R1 reset data", byteData, 0);
    chk("R1 reset idx", byteIdx, 0);
    rstN = 1'b1;
    tick();

    // R2: other inputs ignored while idle
    energySq = 16'd999; acqDone = 1'b1; tmplDone = 1'b1; corrValid = 1'b1;
    corrMag = 16'd900; bitValid = 1'b1; bitIn = 1'b1;
    repeat (4) tick();
    energySq = 16'd0; acqDone = 1'b0; tmplDone = 1'b0; corrValid = 1'b0;
    corrMag = 16'd0; bitValid = 1'b0;
    chk("R2 idle hold", rxState, 0);

    // R3: equal value does not cross
    pulse(hostReady);
    energySq = 16'd100;
    repeat (3) tick();
    chk("R3 equal no cross", rxState, 1);
    energySq = 16'd101;
    tick();
    energySq = 16'd0;
    chk("R3 cross", rxState, 2);

    // R4: fail wins over done; weak verify returns
    acqDone = 1'b1; acqFail = 1'b1;
    tick();
    acqDone = 1'b0; acqFail = 1'b0;
    chk("R4 fail priority", rxState, 1);
    energySq = 16'd200; tick(); energySq = 16'd0;
    pulse(acqDone);
    chk("R4 to verify", rxState, 3);
    corrMag = 16'd500;
    pulse(corrValid);
    corrMag = 16'd0;
    chk("R4 verify equal fails", rxState, 1);

    // R6: cleared history must not fake a match after 7 bits
    energySq = 16'd200; tick(); energySq = 16'd0;
    pulse(acqDone);
    corrMag = 16'd600; pulse(corrValid); corrMag = 16'd0;
    pulse(tmplDone);
    chk("R5 search", rxState, 5);
    for (int i = 0; i < 7; i++) sendBit(i[0] ? 1'b0 : 1'b1);
    chk("R6 seven bits no match", rxState, 5);
    sendBit(1'b0);
    chk("R6 no match on 0xAA", rxState, 5);

    // R7: weak correlation abandons search
    corrMag = 16'd499;
    pulse(corrValid);
    corrMag = 16'd0;
    chk("R7 abandon", rxState, 1);

    // R7: abandon wins over a match in the same cycle
    energySq = 16'd200; tick(); energySq = 16'd0;
    pulse(acqDone);
    corrMag = 16'd600; pulse(corrValid); corrMag = 16'd0;
    pulse(tmplDone);
    for (int i = 0; i < 12; i++) sendBit(1'b1);
    for (int i = 7; i >= 1; i--) sendBit(i[0] ? 1'b0 : 1'b1);
    corrMag = 16'd10; corrValid = 1'b1;
    sendBit(1'b1);
    corrValid = 1'b0; corrMag = 16'd0;
    chk("R7 abandon over match", rxState, 1);
    energySq = 16'd0;
    // bring back to idle through a full zero-length packet path
    energySq = 16'd200; tick(); energySq = 16'd0;
    pulse(acqDone);
    corrMag = 16'd600; pulse(corrValid); corrMag = 16'd0;
    pulse(tmplDone);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    sendByte(8'h55);
    sendByte(8'h00);
    chk("R8 zero length ready", pktReady, 1);
    chk("R8 zero length idle", rxState, 0);
    tick();

    // Directed sample packet, then random packets
    runPacket(32, 3);
    runPacket(8, 1);
    for (int n = 0; n < 20; n++) begin
      runPacket($urandom_range(8, 40), $urandom_range(0, 6));
      repeat ($urandom_range(0, 3)) tick();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule